// File: doc/BRIEF.md
# Inverted Event Sample Filter

This block decides, for each candidate profiling sample, whether the sample must be thrown away because of the events it carries. A 64-bit filter register holds one enable per event position. When the global filter enable is high and any event that the sample carries has its filter bit set, the sample is rejected. An event whose filter bit is clear never influences the decision.

Software loads and reads the filter register through a plain write-enable and data port. A write keeps only the positions that are defined as writable. Bit 0 and the band of bits 32 to 47 are reserved. They read back as zero and cannot be set. Bit 1, the speculative-event filter, becomes reserved in the same way when the build has no speculative-sample support. A build that leaves the register out entirely reads zero, ignores writes and never rejects a sample.

Each sample arrives with a valid strobe and an event vector. The decision leaves a register one clock later and carries its own valid strobe.

Top module: `evf_sample_filter`

## Requirements
- R1: After reset the filter register reads as all zeros and `dec_valid` is low. A sample taken before any write is kept, whatever events it carries.
- R2: A write stores `reg_wdata` with bit 0 and bits 32..47 forced to zero. `reg_rdata` shows the stored value from the clock after the write.
- R3: When `filt_en` is 1, a sample is dropped (`dec_drop`=1) if the bitwise AND of the filter register and `smp_events` is nonzero. Any single matching position is enough; for example, filter bits 3 and 5 reject event 3, event 5, or both.
- R4: An event set in `smp_events` at a position whose filter bit is 0 does not affect the decision. This includes the reserved positions 0 and 32..47, even after all-ones is written.
- R5: When `filt_en` is 0, every sample is kept, whatever the register and events hold.
- R6: `dec_valid` equals `smp_valid` delayed by one clock, and `dec_drop` is 0 whenever `dec_valid` is 0.
- R7: When a sample and a register write occur in the same cycle, the decision uses the register value from before the write.
- R8: With `SPEC_SUPPORT`=0, bit 1 reads as zero, ignores writes and never causes a drop.
- R9: With `PRESENT`=0, `reg_rdata` is always zero, writes have no effect, and no sample is ever dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Filter register write strobe |
| reg_wdata | input | EV_W | Filter register write data |
| reg_rdata | output | EV_W | Filter register read value |
| filt_en | input | 1 | Global filter enable |
| smp_valid | input | 1 | Sample valid strobe |
| smp_events | input | EV_W | Event vector of the sample |
| dec_valid | output | 1 | Decision valid, one clock after `smp_valid` |
| dec_drop | output | 1 | 1 = reject the sample, 0 = keep it |

## Verification
A write becomes visible on `reg_rdata` right after the clock edge that captures it. A sample presented at one edge has its decision on `dec_valid` and `dec_drop` right after that same edge, which is one register stage. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples both results on the following falling edge. The same-cycle write and sample case is checked on that same edge, so it shows that the decision was taken from the old register contents. The speculative-less and absent variants are separate instances fed the same stimulus, each with its own expected value.

// File: rtl/evf_pkg.sv
package evf_pkg;
   // Positions whose meaning the decode depends on
   localparam int unsigned EVF_RSV_BIT   = 0;
   localparam int unsigned EVF_SPEC_BIT  = 1;
   localparam int unsigned EVF_DEF_W     = 64;
   localparam int unsigned EVF_DEF_RLO   = 32;
   localparam int unsigned EVF_DEF_RHI   = 47;

   typedef struct packed {
      logic valid;
      logic drop;
   } evf_dec_t;
endpackage

// File: rtl/evf_wr_mask.sv
module evf_wr_mask #(
   parameter int unsigned EV_W         = evf_pkg::EVF_DEF_W,
   parameter int unsigned RSV_LO       = evf_pkg::EVF_DEF_RLO,
   parameter int unsigned RSV_HI       = evf_pkg::EVF_DEF_RHI,
   parameter bit          SPEC_SUPPORT = 1'b1,
   parameter bit          PRESENT      = 1'b1
) (
   output logic [EV_W-1:0] wmask
);
   for (genvar i = 0; i < EV_W; i++) begin : g_bit
      localparam bit IS_RSV  = (i == evf_pkg::EVF_RSV_BIT) ||
                               (i >= RSV_LO && i <= RSV_HI);
      localparam bit IS_SPEC = (i == evf_pkg::EVF_SPEC_BIT);
      if (!PRESENT || IS_RSV || (IS_SPEC && !SPEC_SUPPORT)) begin : g_fixed
         assign wmask[i] = 1'b0;
      end else begin : g_live
         assign wmask[i] = 1'b1;
      end
   end
endmodule

// File: rtl/evf_ctrl_reg.sv
module evf_ctrl_reg #(
   parameter int unsigned EV_W    = evf_pkg::EVF_DEF_W,
   parameter bit          PRESENT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [EV_W-1:0] wdata,
   input  logic [EV_W-1:0] wmask,
   output logic [EV_W-1:0] cfg_q
);
   if (PRESENT) begin : g_store
      logic [EV_W-1:0] cfg_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cfg_r <= '0;
         else if (wr_en) cfg_r <= wdata & wmask;
      end
      assign cfg_q = cfg_r;

      // R2: a write lands masked, visible on the next cycle
      a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> cfg_q == ($past(wdata) & wmask));
      // R2: without a write the stored value holds
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(cfg_q));
   end else begin : g_absent
      assign cfg_q = '0;
   end
endmodule

// File: rtl/evf_drop_eval.sv
module evf_drop_eval #(
   parameter int unsigned EV_W = evf_pkg::EVF_DEF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EV_W-1:0] cfg,
   input  logic            filt_en,
   input  logic            smp_valid,
   input  logic [EV_W-1:0] smp_events,
   output evf_pkg::evf_dec_t dec
);
   logic hit;
   evf_pkg::evf_dec_t dec_d;

   assign hit         = |(cfg & smp_events);
   assign dec_d.valid = smp_valid;
   assign dec_d.drop  = smp_valid & filt_en & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec <= '0;
      else        dec <= dec_d;
   end

   // R6: valid follows the strobe by one clock
   a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> dec.valid);
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !dec.valid);
   // R6: drop only qualified by valid
   a_r6_drop_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !dec.valid |-> !dec.drop);
   // R5: bypass keeps every sample
   a_r5_bypass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en |=> !dec.drop);
   // R3: enabled match rejects
   a_r3_match_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && filt_en && (cfg & smp_events) != '0) |=> dec.drop);
   // R4: no overlap never rejects
   a_r4_no_overlap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg & smp_events) == '0) |=> !dec.drop);
endmodule

// File: rtl/evf_sample_filter.sv
module evf_sample_filter #(
   parameter int unsigned EV_W         = evf_pkg::EVF_DEF_W,
   parameter int unsigned RSV_LO       = evf_pkg::EVF_DEF_RLO,
   parameter int unsigned RSV_HI       = evf_pkg::EVF_DEF_RHI,
   parameter bit          SPEC_SUPPORT = 1'b1,
   parameter bit          PRESENT      = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr_en,
   input  logic [EV_W-1:0] reg_wdata,
   output logic [EV_W-1:0] reg_rdata,
   input  logic            filt_en,
   input  logic            smp_valid,
   input  logic [EV_W-1:0] smp_events,
   output logic            dec_valid,
   output logic            dec_drop
);
   // Elaboration-time parameter checks
   if (EV_W < 2) begin : g_bad_width
      $error("evf_sample_filter: EV_W must be at least 2");
   end
   if (RSV_LO > RSV_HI || RSV_HI >= EV_W) begin : g_bad_band
      $error("evf_sample_filter: reserved band out of range");
   end
   if (RSV_LO <= evf_pkg::EVF_SPEC_BIT) begin : g_bad_overlap
      $error("evf_sample_filter: reserved band overlaps bits 0..1");
   end

   logic [EV_W-1:0]   wmask;
   logic [EV_W-1:0]   cfg_q;
   evf_pkg::evf_dec_t dec;

   evf_wr_mask #(
      .EV_W(EV_W), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI),
      .SPEC_SUPPORT(SPEC_SUPPORT), .PRESENT(PRESENT)
   ) u_mask (
      .wmask(wmask)
   );

   evf_ctrl_reg #(.EV_W(EV_W), .PRESENT(PRESENT)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
      .wdata(reg_wdata), .wmask(wmask), .cfg_q(cfg_q)
   );

   evf_drop_eval #(.EV_W(EV_W)) u_eval (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .filt_en(filt_en),
      .smp_valid(smp_valid), .smp_events(smp_events), .dec(dec)
   );

   assign reg_rdata = cfg_q;
   assign dec_valid = dec.valid;
   assign dec_drop  = dec.drop;

   // R2: reserved positions never read as one
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[evf_pkg::EVF_RSV_BIT] == 1'b0 && reg_rdata[RSV_HI:RSV_LO] == '0);
   // R7: a sample beside a write is judged on the old contents
   a_r7_old_value: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && filt_en && reg_wr_en) |=>
         dec_drop == ($past(reg_rdata & smp_events) != '0));

   if (!SPEC_SUPPORT) begin : g_chk_nospec
      // R8: speculative position fixed at zero
      a_r8_spec_zero: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[evf_pkg::EVF_SPEC_BIT] == 1'b0);
   end
   if (!PRESENT) begin : g_chk_absent
      // R9: absent register reads zero and never rejects
      a_r9_absent_inert: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata == '0 && !dec_drop);
   end
endmodule

// File: tb/tb_evf_sample_filter.sv
module tb_evf_sample_filter;
   localparam int W = 64;
   localparam logic [W-1:0] MASK_FULL   = 64'hFFFF_0000_FFFF_FFFE;
   localparam logic [W-1:0] MASK_NOSPEC = 64'hFFFF_0000_FFFF_FFFC;

   typedef struct packed {
      logic [W-1:0] cfg;
      logic         en;
      logic [W-1:0] ev;
      logic         drop;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{64'h28,                   1'b1, 64'h08,                   1'b1},
      '{64'h28,                   1'b1, 64'h20,                   1'b1},
      '{64'h28,                   1'b1, 64'h28,                   1'b1},
      '{64'h28,                   1'b1, 64'h14,                   1'b0},
      '{64'h28,                   1'b0, 64'h28,                   1'b0},
      '{64'hFFFF_FFFF_FFFF_FFFF,  1'b1, 64'h1,                    1'b0},
      '{64'hFFFF_FFFF_FFFF_FFFF,  1'b1, 64'h0000_FFFF_0000_0000,  1'b0},
      '{64'hFFFF_FFFF_FFFF_FFFF,  1'b1, 64'h0001_0000_0000_0000,  1'b1},
      '{64'h8000_0000_0000_0000,  1'b1, 64'h8000_0000_0000_0000,  1'b1},
      '{64'h2,                    1'b1, 64'h2,                    1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic filt_en = 1'b0;
   logic smp_valid = 1'b0;
   logic [W-1:0] smp_events = '0;
   logic [W-1:0] rd_a, rd_b, rd_c;
   logic dv_a, dv_b, dv_c, dd_a, dd_b, dd_c;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   evf_sample_filter dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(rd_a), .filt_en(filt_en), .smp_valid(smp_valid),
      .smp_events(smp_events), .dec_valid(dv_a), .dec_drop(dd_a));

   evf_sample_filter #(.SPEC_SUPPORT(1'b0)) dut_nospec (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(rd_b), .filt_en(filt_en), .smp_valid(smp_valid),
      .smp_events(smp_events), .dec_valid(dv_b), .dec_drop(dd_b));

   evf_sample_filter #(.PRESENT(1'b0)) dut_absent (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(rd_c), .filt_en(filt_en), .smp_valid(smp_valid),
      .smp_events(smp_events), .dec_valid(dv_c), .dec_drop(dd_c));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [W-1:0] v);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      tick();
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic sample(input logic en, input logic [W-1:0] ev);
      filt_en    = en;
      smp_valid  = 1'b1;
      smp_events = ev;
      tick();
      smp_valid  = 1'b0;
      smp_events = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata", rd_a, '0);
      check("R1 dec_valid", {63'b0, dv_a}, 64'h0);
      rst_n = 1'b1;
      tick();
      check("R1 rdata after release", rd_a, '0);
      sample(1'b1, '1);
      check("R1 keep before write", {62'b0, dv_a, dd_a}, 64'h2);

      // R6: no strobe gives no decision
      filt_en = 1'b1;
      smp_events = '1;
      tick();
      check("R6 idle valid/drop", {62'b0, dv_a, dd_a}, 64'h0);
      smp_events = '0;

      // Table walk: R2 readback, R3/R4/R5 decisions, R8/R9 variants
      for (int i = 0; i < NV; i++) begin
         write_cfg(VECS[i].cfg);
         check("R2 readback", rd_a, VECS[i].cfg & MASK_FULL);
         check("R8 readback nospec", rd_b, VECS[i].cfg & MASK_NOSPEC);
         check("R9 readback absent", rd_c, '0);
         sample(VECS[i].en, VECS[i].ev);
         check("R3/R4/R5 decision", {62'b0, dv_a, dd_a}, {62'b0, 1'b1, VECS[i].drop});
         check("R8 decision nospec", {63'b0, dd_b},
               {63'b0, VECS[i].en & (|(VECS[i].cfg & VECS[i].ev & MASK_NOSPEC))});
         check("R9 decision absent", {62'b0, dv_c, dd_c}, 64'h2);
      end

      // R5: bypass with full overlap
      write_cfg('1);
      sample(1'b0, '1);
      check("R5 bypass", {62'b0, dv_a, dd_a}, 64'h2);

      // R7: same-cycle write and sample uses the old contents
      write_cfg(64'h8);
      reg_wr_en  = 1'b1;
      reg_wdata  = '0;
      filt_en    = 1'b1;
      smp_valid  = 1'b1;
      smp_events = 64'h8;
      tick();
      reg_wr_en  = 1'b0;
      smp_valid  = 1'b0;
      check("R7 old value drops", {63'b0, dd_a}, 64'h1);
      check("R7 new value stored", rd_a, '0);
      sample(1'b1, 64'h8);
      check("R7 next sample kept", {63'b0, dd_a}, 64'h0);

      // R6: decision holds one cycle only
      tick();
      check("R6 valid drops after one", {63'b0, dv_a}, 64'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule